// File: doc/BRIEF.md
# Ventilation Fan Start Interlock

This block decides when a ventilation fan runs. It reads a spring-return hand switch with three contacts (start, auto, stop), a safety demand input, a low-airflow bit from this fan's flow sensor, and a low-airflow bit reported by a companion fan. It drives a registered run command to the motor starter and a registered low-flow alarm.

A safety demand counts toward an automatic start only after it has been held without a break for longer than a programmable number of timing ticks. Once the demand is qualified, the auto contact can start the fan. The start contact can always start it. The run command is kept in a retentive latch, so it stays on after the cause of the start goes away. Only the stop contact clears it, and stop has priority over any start request in the same cycle. While the fan runs, a supervision timer counts ticks from the start. After its preset, a low local airflow bit raises the alarm. The companion fan's low-flow bit raises the alarm at any time. All delays are counted on a one-cycle tick enable, so the same logic works for any tick rate.

Top module: `fan_interlock`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `run_cmd` and `flow_alarm` are 0.
- R2: When `sw_start` is 1 and `sw_stop` is 0 at a clock edge, `run_cmd` is 1 after that edge.
- R3: The safety demand becomes qualified only after `safety_in` has been 1 for more than `SAFE_TICKS` tick edges in a row. If it has been held for exactly `SAFE_TICKS` ticks, or held with no ticks at all, the fan does not start.
- R4: If `safety_in` returns to 0, the tick count restarts from zero. Ticks counted before the drop do not count toward qualification.
- R5: An automatic start needs `sw_auto` = 1 and a qualified demand in the same cycle. A qualified demand with no contact closed does not start the fan.
- R6: Once set, `run_cmd` stays 1 while `sw_stop` is 0, even after `sw_start`, `sw_auto` or `safety_in` go to 0.
- R7: When `sw_stop` is 1 at a clock edge, `run_cmd` is 0 after it. This holds even if `sw_start` is 1 or a qualified auto start is present in the same cycle.
- R8: If the demand is still qualified when the switch goes from stop back to auto, the fan restarts on the next edge.
- R9: `flow_alarm` follows `flow_low_local` with one cycle of delay, but only while the fan runs and after `SUP_TICKS` ticks have been counted since `run_cmd` rose. Before that point a low local flow bit is ignored. When the bit clears, the alarm clears.
- R10: The supervision count is cleared while the fan is stopped, so every new start waits the full `SUP_TICKS` ticks again.
- R11: `flow_low_peer` = 1 sets `flow_alarm` one cycle later, whether or not the fan runs (OR of the two terms).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timing enable that advances both timers |
| sw_start | input | 1 | Hand switch start contact |
| sw_auto | input | 1 | Hand switch auto contact |
| sw_stop | input | 1 | Hand switch stop contact |
| safety_in | input | 1 | Safety demand |
| flow_low_local | input | 1 | This fan's airflow is below its limit |
| flow_low_peer | input | 1 | The companion fan reports low airflow |
| run_cmd | output | 1 | Fan run command |
| flow_alarm | output | 1 | Low-flow alarm |

## Verification
The assertions assume that every input is synchronous to `clk` and settled before each edge. They also assume that the tick count derived from `safety_in` and `tick` is the only thing that qualifies a demand. The properties do not assume the switch contacts are mutually exclusive, because a worn switch can close two contacts at once. The stimulus therefore includes one cycle with both start and stop closed, to exercise the stop priority. Ticks are always single-cycle pulses driven between edges, so every count the bench expects is an exact number of ticks.

// File: rtl/fan_interlock_pkg.sv
package fan_interlock_pkg;

    // Hand switch contacts as seen by the interlock.
    typedef struct packed {
        logic start;
        logic autom;
        logic stop;
    } contacts_t;

    // Reset has priority over set.
    function automatic logic latch_next(input logic cur, input logic set, input logic clr);
        if (clr)      return 1'b0;
        else if (set) return 1'b1;
        else          return cur;
    endfunction

endpackage

// File: rtl/fi_qualify_timer.sv
module fi_qualify_timer #(
    parameter int SAFE_TICKS = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic safety_i,
    output logic qual_o
);
    localparam int QW = $clog2(SAFE_TICKS + 2);
    localparam logic [QW-1:0] Q_LIMIT = QW'(SAFE_TICKS + 1);

    typedef struct packed {
        logic [QW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!safety_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != Q_LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The output drops as soon as the demand drops.
    assign qual_o = safety_i && (st_q.cnt == Q_LIMIT);

endmodule

// File: rtl/fi_run_latch.sv
module fi_run_latch
    import fan_interlock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  contacts_t sw_i,
    input  logic      qual_i,
    output logic      run_o
);
    typedef struct packed {
        logic run;
    } state_t;

    state_t st_d, st_q;
    logic   set_w;
    logic   clr_w;

    always_comb begin
        set_w      = sw_i.start || (sw_i.autom && qual_i);
        clr_w      = sw_i.stop;
        st_d       = st_q;
        st_d.run   = latch_next(st_q.run, set_w, clr_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;

endmodule

// File: rtl/fi_flow_supervisor.sv
module fi_flow_supervisor #(
    parameter int SUP_TICKS = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic low_local_i,
    input  logic low_peer_i,
    output logic alarm_o
);
    localparam int SW = $clog2(SUP_TICKS + 1);
    localparam logic [SW-1:0] S_LIMIT = SW'(SUP_TICKS);

    typedef struct packed {
        logic [SW-1:0] cnt;
        logic          alarm;
    } state_t;

    state_t st_d, st_q;
    logic   armed_w;

    always_comb begin
        st_d    = st_q;
        armed_w = run_i && (st_q.cnt == S_LIMIT);
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != S_LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.alarm = (armed_w && low_local_i) || low_peer_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm_o = st_q.alarm;

endmodule

// File: rtl/fan_interlock.sv
module fan_interlock
    import fan_interlock_pkg::*;
#(
    parameter int SAFE_TICKS = 600,
    parameter int SUP_TICKS  = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sw_start,
    input  logic sw_auto,
    input  logic sw_stop,
    input  logic safety_in,
    input  logic flow_low_local,
    input  logic flow_low_peer,
    output logic run_cmd,
    output logic flow_alarm
);
    contacts_t sw_w;
    logic      qual_w;
    logic      run_w;

    always_comb begin
        sw_w.start = sw_start;
        sw_w.autom = sw_auto;
        sw_w.stop  = sw_stop;
    end

    fi_qualify_timer #(.SAFE_TICKS(SAFE_TICKS)) i_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .safety_i (safety_in),
        .qual_o   (qual_w)
    );

    fi_run_latch i_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_i   (sw_w),
        .qual_i (qual_w),
        .run_o  (run_w)
    );

    fi_flow_supervisor #(.SUP_TICKS(SUP_TICKS)) i_sup (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .run_i       (run_w),
        .low_local_i (flow_low_local),
        .low_peer_i  (flow_low_peer),
        .alarm_o     (flow_alarm)
    );

    assign run_cmd = run_w;

endmodule

// File: rtl/fan_interlock_chk.sv
module fan_interlock_chk #(
    parameter int SAFE_TICKS = 600
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic sw_start,
    input logic sw_auto,
    input logic sw_stop,
    input logic safety_in,
    input logic flow_low_local,
    input logic flow_low_peer,
    input logic run_cmd,
    input logic flow_alarm
);
    localparam int CW = $clog2(SAFE_TICKS + 2);
    localparam logic [CW-1:0] C_LIMIT = CW'(SAFE_TICKS + 1);

    // Ticks seen while the demand has been held without a break.
    logic [CW-1:0] held_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !safety_in)               held_q <= '0;
        else if (tick && held_q != C_LIMIT)     held_q <= held_q + 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!run_cmd && !flow_alarm));

    p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start && !sw_stop) |=> run_cmd);

    p_no_early_auto_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_cmd && !sw_start && held_q != C_LIMIT) |=> !run_cmd);

    p_no_cause_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_cmd && !sw_start && !(sw_auto && safety_in)) |=> !run_cmd);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cmd && !sw_stop) |=> run_cmd);

    p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> !run_cmd);

    p_alarm_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_low_peer && !(run_cmd && flow_low_local)) |=> !flow_alarm);

    p_peer_alarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flow_low_peer |=> flow_alarm);

endmodule

bind fan_interlock fan_interlock_chk #(.SAFE_TICKS(SAFE_TICKS)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .sw_start       (sw_start),
    .sw_auto        (sw_auto),
    .sw_stop        (sw_stop),
    .safety_in      (safety_in),
    .flow_low_local (flow_low_local),
    .flow_low_peer  (flow_low_peer),
    .run_cmd        (run_cmd),
    .flow_alarm     (flow_alarm)
);

// File: tb/test_fan_interlock.sv
module test_fan_interlock;
    localparam int CLK_PERIOD = 10;
    localparam int SAFE_T     = 4;
    localparam int SUP_T      = 3;

    logic clk = 1'b0;
    logic rst_n, tick, sw_start, sw_auto, sw_stop;
    logic safety_in, flow_low_local, flow_low_peer;
    logic run_cmd, flow_alarm;

    int n_total = 0;
    int n_bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_interlock #(.SAFE_TICKS(SAFE_T), .SUP_TICKS(SUP_T)) i_fan_interlock (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .sw_start       (sw_start),
        .sw_auto        (sw_auto),
        .sw_stop        (sw_stop),
        .safety_in      (safety_in),
        .flow_low_local (flow_low_local),
        .flow_low_peer  (flow_low_peer),
        .run_cmd        (run_cmd),
        .flow_alarm     (flow_alarm)
    );

    typedef struct {
        string tag;
        logic  chk_run;
        logic  run;
        logic  chk_alarm;
        logic  alarm;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    // Monitor: compares queued expectations mid-cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            if (cur.chk_run) begin
                n_total++;
                if (run_cmd !== cur.run) begin
                    n_bad++;
                    $display("FAIL %s run_cmd actual=%b expected=%b", cur.tag, run_cmd, cur.run);
                end
            end
            if (cur.chk_alarm) begin
                n_total++;
                if (flow_alarm !== cur.alarm) begin
                    n_bad++;
                    $display("FAIL %s flow_alarm actual=%b expected=%b", cur.tag, flow_alarm, cur.alarm);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse(input int n);
        repeat (n) begin
            tick = 1'b1;
            step(1);
            tick = 1'b0;
            step(1);
        end
    endtask

    task automatic exp_run(input string tag, input logic r);
        exp_t e;
        e.tag = tag; e.chk_run = 1'b1; e.run = r; e.chk_alarm = 1'b0; e.alarm = 1'b0;
        sb_q.push_back(e);
    endtask

    task automatic exp_alarm(input string tag, input logic a);
        exp_t e;
        e.tag = tag; e.chk_run = 1'b0; e.run = 1'b0; e.chk_alarm = 1'b1; e.alarm = a;
        sb_q.push_back(e);
    endtask

    task automatic set_sw(input logic st, input logic au, input logic sp);
        sw_start = st; sw_auto = au; sw_stop = sp;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; set_sw(1'b0, 1'b1, 1'b0);
        safety_in = 1'b0; flow_low_local = 1'b0; flow_low_peer = 1'b0;
        step(3);
        exp_run("R1 reset run", 1'b0);
        exp_alarm("R1 reset alarm", 1'b0);
        rst_n = 1'b1;
        step(1);
        exp_run("R1 after release run", 1'b0);
        exp_alarm("R1 after release alarm", 1'b0);

        // Manual start and retention.
        set_sw(1'b1, 1'b0, 1'b0); step(1);
        exp_run("R2 start contact", 1'b1);
        set_sw(1'b0, 1'b1, 1'b0); step(3);
        exp_run("R6 held after start released", 1'b1);
        exp_alarm("R9 no low flow no alarm", 1'b0);

        // Stop, then stop priority.
        set_sw(1'b0, 1'b0, 1'b1); step(1);
        exp_run("R7 stop clears", 1'b0);
        set_sw(1'b0, 1'b1, 1'b0); step(2);
        exp_run("R5 auto without demand", 1'b0);
        set_sw(1'b1, 1'b0, 1'b1); step(2);
        exp_run("R7 stop beats start", 1'b0);
        set_sw(1'b0, 1'b1, 1'b0); step(1);

        // Qualification with a break in the demand.
        safety_in = 1'b1; pulse(3);
        safety_in = 1'b0; step(1);
        safety_in = 1'b1; pulse(3);
        exp_run("R4 count restarted after drop", 1'b0);
        pulse(1);
        exp_run("R3 exactly SAFE ticks not enough", 1'b0);
        pulse(1);
        exp_run("R3 qualified auto start", 1'b1);

        safety_in = 1'b0; step(2);
        exp_run("R6 held after demand removed", 1'b1);

        // Qualify while stopped, then return to auto.
        set_sw(1'b0, 1'b0, 1'b1); step(1);
        exp_run("R7 stop while running", 1'b0);
        safety_in = 1'b1; pulse(5);
        exp_run("R7 stop held with qualified demand", 1'b0);
        set_sw(1'b0, 1'b1, 1'b0); step(1);
        exp_run("R8 restart on return to auto", 1'b1);

        set_sw(1'b0, 1'b0, 1'b1); step(1);
        set_sw(1'b0, 1'b0, 1'b0); step(2);
        exp_run("R5 qualified demand without auto", 1'b0);
        set_sw(1'b0, 1'b1, 1'b0); step(1);
        exp_run("R5 auto plus qualified demand", 1'b1);
        safety_in = 1'b0;

        // Supervision of local airflow.
        flow_low_local = 1'b1; step(1);
        exp_alarm("R9 low flow ignored at start", 1'b0);
        pulse(2);
        exp_alarm("R9 low flow ignored before preset", 1'b0);
        pulse(1);
        exp_alarm("R9 alarm after preset", 1'b1);
        flow_low_local = 1'b0; step(1);
        exp_alarm("R9 alarm clears on recovery", 1'b0);
        flow_low_local = 1'b1; step(1);
        exp_alarm("R9 alarm returns", 1'b1);

        set_sw(1'b0, 1'b0, 1'b1); step(2);
        exp_run("R10 stopped", 1'b0);
        exp_alarm("R10 alarm off when stopped", 1'b0);
        set_sw(1'b1, 1'b0, 1'b0); step(1);
        set_sw(1'b0, 1'b1, 1'b0); step(1);
        exp_run("R10 restarted", 1'b1);
        exp_alarm("R10 timer restarted", 1'b0);
        pulse(2);
        exp_alarm("R10 still before preset", 1'b0);
        pulse(1);
        exp_alarm("R10 alarm after new preset", 1'b1);

        // Companion fan.
        set_sw(1'b0, 1'b0, 1'b1); flow_low_local = 1'b0; step(2);
        exp_alarm("R11 quiet before peer", 1'b0);
        flow_low_peer = 1'b1; step(1);
        exp_alarm("R11 peer sets alarm while stopped", 1'b1);
        flow_low_peer = 1'b0; step(1);
        exp_alarm("R11 peer cleared", 1'b0);

        // Demand held with no ticks never qualifies.
        set_sw(1'b0, 1'b1, 1'b0); safety_in = 1'b1; step(20);
        exp_run("R3 no ticks no start", 1'b0);
        safety_in = 1'b0;

        step(2);
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule